// File: doc/BRIEF.md
# Serial EEPROM Random-Read Bus Master

This block is a bit-level two-wire bus master that fetches a run of bytes from a serial EEPROM, starting at a chosen word offset. A single start request carries the offset and a byte count. The block then sets the EEPROM's address pointer with a short write phase, turns the bus around with a repeated START, and clocks the requested bytes in. Each received byte is handed out on a valid/ready stream. Both bus lines are treated as open-drain. An output-enable pulls a line low and a released line floats high. The SDA level is read back through an input. A divider paces every bus event in quarter-bit steps.

While the EEPROM is still committing an earlier internal write, it will not acknowledge its device address. In that case the master does not re-sample the line without clocking it. Instead it issues a fresh START and sends the device address again, up to a parameterised number of attempts. Any failed handshake ends the transaction with a STOP and sets a sticky error flag. A new request clears that flag.

Top module: `eeprom_rd_master`

## Requirements
- R1: After reset, busy, errFlag and rdValid are 0 and both line enables (sclOe, sdaOe) are 0, so both lines are released.
- R2: Every START is a fall of SDA while SCL is high. It is preceded by both lines being released high for at least one quarter-bit period (QUARTER_DIV clock cycles).
- R3: A transaction sends three bytes, MSB first, in this order: device byte 0xA0 (bit 0 = 0, write), then the offset byte, then a repeated START, then device byte 0xA1 (bit 0 = 1, read). Outside START and STOP, SDA changes only while SCL is low.
- R4: After each sent byte, the master releases SDA for a ninth clock pulse and samples it while SCL is high. A low level is an acknowledge.
- R5: Received bytes are assembled MSB first and delivered in address order on rdData/rdValid. While rdValid=1 and rdReady=0, rdData holds steady and SCL is held low.
- R6: The master pulls SDA low for the ninth pulse after every received byte except the last. It leaves SDA released after the last byte and then issues a STOP (SDA rises while SCL is high). A byteCount of 0 reads one byte.
- R7: A missing acknowledge on the write-phase device byte makes the master issue a new START and resend 0xA0, until the device acknowledges. The data read afterwards is unaffected.
- R8: If MAX_POLL device-byte attempts all go unacknowledged, the master sets errFlag, issues one STOP and delivers no byte.
- R9: A missing acknowledge on the offset byte or on the read-phase device byte sets errFlag, issues a STOP and delivers no byte.
- R10: A startReq while busy=1 is ignored. The running transaction keeps its offset and count, and no extra START is produced.
- R11: During a byte, consecutive rising edges of SCL are 4*QUARTER_DIV clock cycles apart.
- R12: errFlag stays set after an aborted transaction and clears on the clock edge that accepts the next startReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a transaction (taken only while idle) |
| wordOffset | input | 8 | EEPROM word offset of the first byte |
| byteCount | input | LEN_W | Number of bytes to read (0 reads one) |
| busy | output | 1 | Transaction in progress |
| errFlag | output | 1 | Last transaction aborted on a missing acknowledge |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| sdaIn | input | 1 | Level seen on SDA |
| rdData | output | 8 | Received byte |
| rdValid | output | 1 | rdData holds a byte not yet taken |
| rdReady | input | 1 | Consumer takes the byte when high with rdValid |

## Verification
A request is taken on the clock edge where startReq is seen, so busy and the cleared errFlag are checked one cycle later, at the following falling edge. The line enables trail the controller by one register, and the EEPROM model reacts one clock after it sees an edge. The end-of-transaction counts are therefore read only after busy has fallen and a few more idle cycles have passed, which leaves room for the STOP to reach the model. The SCL period is measured between the second and third releases of SCL after a start, where the spacing must be exactly four quarters. The stream stall is held for 40 cycles before SCL, rdValid and rdData are checked.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  // Source of the next SDA enable value
  typedef enum logic [1:0] {
    SDA_HOLD  = 2'd0,
    SDA_REL   = 2'd1,
    SDA_LOW   = 2'd2,
    SDA_TXBIT = 2'd3
  } sdaSrcE;

  // Which byte is loaded into the transmit shifter
  typedef enum logic [1:0] {
    TX_ADDR_W = 2'd0,
    TX_OFFSET = 2'd1,
    TX_ADDR_R = 2'd2
  } txSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic   divClr;
    logic   latchReq;
    logic   sclPull;
    sdaSrcE sdaSrc;
    logic   condOk;
    logic   loadTx;
    txSelE  txSel;
    logic   shiftTx;
    logic   sampleRx;
    logic   pushByte;
  } strobeT;

  localparam logic [6:0] DEV_ID = 7'h50;

endpackage

// File: rtl/eeprom_rd_datapath.sv
module eeprom_rd_datapath
  import eeprom_rd_pkg::*;
#(
  parameter int QUARTER_DIV = 78
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [7:0] startOffset,
  input  logic       sdaIn,
  input  logic       rdReady,
  output logic       tick,
  output logic       sdaBit,
  output logic       outFull,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [7:0] rdData,
  output logic       rdValid
);

  localparam int CW = (QUARTER_DIV > 1) ? $clog2(QUARTER_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(QUARTER_DIV - 1);

  logic [CW-1:0] divCnt;
  logic [7:0]    offReg;
  logic [7:0]    txShift;
  logic [7:0]    rxShift;
  logic          sdaMeta;
  logic          sdaSync;

  // quarter-bit divider
  always_ff @(posedge clk) begin
    if (!rstN || stb.divClr) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + CW'(1);
  end
  assign tick = (divCnt == DIV_LAST);

  // SDA input synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaMeta <= 1'b1;
      sdaSync <= 1'b1;
    end else begin
      sdaMeta <= sdaIn;
      sdaSync <= sdaMeta;
    end
  end
  assign sdaBit = sdaSync;

  always_ff @(posedge clk) begin
    if (!rstN) offReg <= '0;
    else if (stb.latchReq) offReg <= startOffset;
  end

  // transmit shifter, MSB leaves first
  always_ff @(posedge clk) begin
    if (!rstN) txShift <= '0;
    else if (stb.loadTx) begin
      case (stb.txSel)
        TX_ADDR_W: txShift <= {DEV_ID, 1'b0};
        TX_OFFSET: txShift <= offReg;
        default:   txShift <= {DEV_ID, 1'b1};
      endcase
    end else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
  end

  // receive shifter and output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.sampleRx) rxShift <= {rxShift[6:0], sdaBit};
      if (stb.pushByte) begin
        rdData  <= {rxShift[6:0], sdaBit};
        rdValid <= 1'b1;
      end else if (rdValid && rdReady) begin
        rdValid <= 1'b0;
      end
    end
  end
  assign outFull = rdValid;

  // registered open-drain enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= stb.sclPull;
      case (stb.sdaSrc)
        SDA_HOLD:  sdaOe <= sdaOe;
        SDA_REL:   sdaOe <= 1'b0;
        SDA_LOW:   sdaOe <= 1'b1;
        default:   sdaOe <= ~txShift[7];
      endcase
    end
  end

  // R5: byte held until taken
  p_hold_stream_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  // R5: no new byte pushed over an untaken one
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushByte |-> (!rdValid || rdReady));

  // R3: SDA moves under a high SCL only for START or STOP
  p_sda_scl_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe) && (sdaOe != $past(sdaOe))) |-> $past(stb.condOk));

endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int MAX_POLL = 8,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] byteCount,
  input  logic             tick,
  input  logic             sdaBit,
  input  logic             outFull,
  output strobeT           stb,
  output logic             busy,
  output logic             errFlag
);

  localparam int PW = $clog2(MAX_POLL + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP} stateE;
  typedef enum logic [1:0] {SG_ADDR_W, SG_OFFSET, SG_ADDR_R} stageE;

  stateE            state;
  stageE            stage;
  logic [1:0]       phase;
  logic [3:0]       bitIdx;
  logic [PW-1:0]    pollCnt;
  logic [LEN_W-1:0] remaining;
  logic             err;

  logic stall, advance, endPhase, ackSeen, lastByte, dataBit;

  assign stall    = (state == ST_RX) && (bitIdx == 4'd8) && (phase == 2'd0) && outFull;
  assign advance  = tick && !stall;
  assign endPhase = advance && (phase == 2'd3);
  assign ackSeen  = !sdaBit;
  assign lastByte = (remaining == LEN_W'(1));
  assign dataBit  = (bitIdx < 4'd8);

  always_comb begin
    stb = '0;
    stb.sdaSrc = SDA_HOLD;
    stb.txSel  = TX_ADDR_W;
    case (state)
      ST_IDLE: begin
        stb.sdaSrc = SDA_REL;
        if (startReq) begin
          stb.latchReq = 1'b1;
          stb.divClr   = 1'b1;
        end
      end
      ST_START: begin
        stb.condOk  = 1'b1;
        stb.sclPull = (phase == 2'd0);
        stb.sdaSrc  = phase[1] ? SDA_LOW : SDA_REL;
        if (endPhase) begin
          stb.loadTx = 1'b1;
          stb.txSel  = (stage == SG_ADDR_R) ? TX_ADDR_R : TX_ADDR_W;
        end
      end
      ST_TX: begin
        stb.sclPull = !phase[1];
        if (phase != 2'd0) stb.sdaSrc = dataBit ? SDA_TXBIT : SDA_REL;
        if (endPhase && dataBit) stb.shiftTx = 1'b1;
        if (endPhase && !dataBit && ackSeen && stage == SG_ADDR_W) begin
          stb.loadTx = 1'b1;
          stb.txSel  = TX_OFFSET;
        end
      end
      ST_RX: begin
        stb.sclPull = !phase[1];
        if (phase != 2'd0) begin
          if (dataBit) stb.sdaSrc = SDA_REL;
          else stb.sdaSrc = lastByte ? SDA_REL : SDA_LOW;
        end
        if (endPhase && dataBit) begin
          stb.sampleRx = 1'b1;
          stb.pushByte = (bitIdx == 4'd7);
        end
      end
      ST_STOP: begin
        stb.condOk  = 1'b1;
        stb.sclPull = !phase[1];
        case (phase)
          2'd0:    stb.sdaSrc = SDA_HOLD;
          2'd3:    stb.sdaSrc = SDA_REL;
          default: stb.sdaSrc = SDA_LOW;
        endcase
      end
      default: stb.sdaSrc = SDA_REL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stage     <= SG_ADDR_W;
      phase     <= '0;
      bitIdx    <= '0;
      pollCnt   <= '0;
      remaining <= '0;
      err       <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (startReq) begin
        state     <= ST_START;
        stage     <= SG_ADDR_W;
        phase     <= '0;
        bitIdx    <= '0;
        pollCnt   <= '0;
        err       <= 1'b0;
        remaining <= (byteCount == '0) ? LEN_W'(1) : byteCount;
      end
    end else if (advance) begin
      phase <= phase + 2'd1;
      if (phase == 2'd3) begin
        case (state)
          ST_START: begin
            state  <= ST_TX;
            bitIdx <= '0;
          end
          ST_TX: begin
            if (dataBit) bitIdx <= bitIdx + 4'd1;
            else begin
              bitIdx <= '0;
              case (stage)
                SG_ADDR_W: begin
                  if (ackSeen) stage <= SG_OFFSET;
                  else if (pollCnt == PW'(MAX_POLL - 1)) begin
                    err   <= 1'b1;
                    state <= ST_STOP;
                  end else begin
                    pollCnt <= pollCnt + PW'(1);
                    state   <= ST_START;
                  end
                end
                SG_OFFSET: begin
                  if (ackSeen) begin
                    stage <= SG_ADDR_R;
                    state <= ST_START;
                  end else begin
                    err   <= 1'b1;
                    state <= ST_STOP;
                  end
                end
                default: begin
                  if (ackSeen) state <= ST_RX;
                  else begin
                    err   <= 1'b1;
                    state <= ST_STOP;
                  end
                end
              endcase
            end
          end
          ST_RX: begin
            if (dataBit) bitIdx <= bitIdx + 4'd1;
            else if (lastByte) state <= ST_STOP;
            else begin
              remaining <= remaining - LEN_W'(1);
              bitIdx    <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign errFlag = err;

  // R8: attempt counter never passes its bound
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(MAX_POLL));

  // R9: an abort always leads through a STOP
  p_err_via_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> (state == ST_STOP));

endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master
  import eeprom_rd_pkg::*;
#(
  parameter int QUARTER_DIV = 78,
  parameter int MAX_POLL    = 8,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [7:0]       wordOffset,
  input  logic [LEN_W-1:0] byteCount,
  output logic             busy,
  output logic             errFlag,
  output logic             sclOe,
  output logic             sdaOe,
  input  logic             sdaIn,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady
);

  strobeT stb;
  logic   tick;
  logic   sdaBit;
  logic   outFull;

  eeprom_rd_ctrl #(.MAX_POLL(MAX_POLL), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .tick(tick), .sdaBit(sdaBit), .outFull(outFull), .stb(stb),
    .busy(busy), .errFlag(errFlag)
  );

  eeprom_rd_datapath #(.QUARTER_DIV(QUARTER_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startOffset(wordOffset),
    .sdaIn(sdaIn), .rdReady(rdReady), .tick(tick), .sdaBit(sdaBit),
    .outFull(outFull), .sclOe(sclOe), .sdaOe(sdaOe),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/eeprom_rd_master_bench.sv
`timescale 1ns/1ps
module eeprom_rd_master_bench;

  localparam int DIV  = 3;
  localparam int POLL = 4;
  localparam int LW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] wordOffset = '0;
  logic [LW-1:0] byteCount = '0;
  logic busy, errFlag, sclOe, sdaOe, sdaIn;
  logic [7:0] rdData;
  logic rdValid;
  logic rdReady = 1'b1;

  always #4 clk = ~clk;

  eeprom_rd_master #(.QUARTER_DIV(DIV), .MAX_POLL(POLL), .LEN_W(LW)) u_eeprom_rd_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordOffset(wordOffset),
    .byteCount(byteCount), .busy(busy), .errFlag(errFlag), .sclOe(sclOe),
    .sdaOe(sdaOe), .sdaIn(sdaIn), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady)
  );

  int nChecks = 0;
  int nFails = 0;
  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [7:0] memVal(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  // ---------------- EEPROM model ----------------
  logic slvPull = 1'b0;
  logic scl, sda;
  assign scl   = ~sclOe;
  assign sda   = ~(sdaOe | slvPull);
  assign sdaIn = sda;

  logic cfgClear = 1'b0;
  int   cfgNacks = 0;
  logic cfgNackOff = 1'b0;
  logic cfgNackRd = 1'b0;

  logic prevScl = 1'b1, prevSda = 1'b1;
  logic sActive = 1'b0, ackBit = 1'b0, enterTx = 1'b0;
  int   bitCnt = 0, mPhase = 0, bothHigh = 0;
  logic [7:0] rxByte = '0, txByte = '0, ptr = '0, offsetSeen = '0;
  int startCnt = 0, stopCnt = 0, nackGiven = 0, seenA0 = 0, seenA1 = 0;
  int masterAcks = 0, masterNacks = 0, minSettle = 1000;

  always @(posedge clk) begin
    prevScl  <= scl;
    prevSda  <= sda;
    bothHigh <= (scl && sda) ? bothHigh + 1 : 0;
    if (cfgClear) begin
      sActive <= 1'b0; ackBit <= 1'b0; enterTx <= 1'b0; slvPull <= 1'b0;
      bitCnt <= 0; mPhase <= 0; startCnt <= 0; stopCnt <= 0; nackGiven <= 0;
      seenA0 <= 0; seenA1 <= 0; masterAcks <= 0; masterNacks <= 0;
      minSettle <= 1000; offsetSeen <= '0;
    end else if (prevScl && scl && prevSda && !sda) begin
      startCnt <= startCnt + 1;
      if (bothHigh < minSettle) minSettle <= bothHigh;
      sActive <= 1'b1; bitCnt <= 0; ackBit <= 1'b0; enterTx <= 1'b0;
      mPhase <= 0; slvPull <= 1'b0;
    end else if (prevScl && scl && !prevSda && sda) begin
      stopCnt <= stopCnt + 1;
      sActive <= 1'b0; slvPull <= 1'b0;
    end else if (sActive && !prevScl && scl) begin
      if (mPhase < 2) begin
        if (!ackBit && bitCnt < 8) begin
          rxByte <= {rxByte[6:0], sda};
          bitCnt <= bitCnt + 1;
        end
      end else if (mPhase == 2) begin
        if (bitCnt < 8) bitCnt <= bitCnt + 1;
        else if (!sda) begin
          masterAcks <= masterAcks + 1;
          ptr    <= ptr + 8'd1;
          txByte <= memVal(ptr + 8'd1);
          bitCnt <= 0;
        end else begin
          masterNacks <= masterNacks + 1;
          mPhase <= 3;
        end
      end
    end else if (sActive && prevScl && !scl) begin
      if (mPhase < 2) begin
        if (ackBit) begin
          slvPull <= 1'b0; ackBit <= 1'b0; bitCnt <= 0;
          if (enterTx) begin
            enterTx <= 1'b0;
            mPhase  <= 2;
            slvPull <= ~txByte[7];
          end
        end else if (bitCnt == 8) begin
          ackBit <= 1'b1;
          if (mPhase == 0) begin
            if (rxByte == 8'hA0) begin
              seenA0 <= seenA0 + 1;
              if (nackGiven < cfgNacks) nackGiven <= nackGiven + 1;
              else begin slvPull <= 1'b1; mPhase <= 1; end
            end else if (rxByte == 8'hA1) begin
              seenA1 <= seenA1 + 1;
              if (!cfgNackRd) begin
                slvPull <= 1'b1; enterTx <= 1'b1; txByte <= memVal(ptr);
              end
            end
          end else begin
            offsetSeen <= rxByte;
            ptr <= rxByte;
            mPhase <= 0;
            if (!cfgNackOff) slvPull <= 1'b1;
          end
        end
      end else if (mPhase == 2) begin
        if (bitCnt < 8) slvPull <= ~txByte[7 - bitCnt];
        else slvPull <= 1'b0;
      end
    end
  end

  // ---------------- stream collector ----------------
  logic [7:0] got [0:15];
  int nGot = 0;
  always @(posedge clk) begin
    if (cfgClear) nGot <= 0;
    else if (rdValid && rdReady && nGot < 16) begin
      got[nGot] <= rdData;
      nGot <= nGot + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearModel(input int nacks, input bit nOff, input bit nRd);
    @(negedge clk);
    cfgNacks = nacks; cfgNackOff = nOff; cfgNackRd = nRd;
    cfgClear = 1'b1;
    @(negedge clk);
    cfgClear = 1'b0;
  endtask

  task automatic pulseStart(input logic [7:0] off, input logic [LW-1:0] cnt);
    @(negedge clk);
    wordOffset = off; byteCount = cnt; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, {tag, " done"}, busy, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkData(input string tag, input logic [7:0] off, input int cnt);
    check(nGot == cnt, {tag, " count"}, nGot, cnt);
    for (int i = 0; i < cnt && i < 16; i++)
      check(got[i] == memVal(off + 8'(i)), {tag, " byte"}, got[i], memVal(off + 8'(i)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check(busy == 0 && errFlag == 0 && rdValid == 0, "R1 status", {busy, errFlag, rdValid}, 0);
    check(sclOe == 0 && sdaOe == 0, "R1 lines", {sclOe, sdaOe}, 0);
  endtask

  task automatic t_basic;
    clearModel(0, 0, 0);
    pulseStart(8'h10, 4);
    waitIdle("R3 basic");
    checkData("R5 basic", 8'h10, 4);
    check(seenA0 == 1 && seenA1 == 1, "R3 device bytes", seenA0 * 10 + seenA1, 11);
    check(offsetSeen == 8'h10, "R3 offset", offsetSeen, 8'h10);
    check(startCnt == 2, "R4 starts", startCnt, 2);
    check(masterAcks == 3 && masterNacks == 1, "R6 ack pattern", masterAcks * 10 + masterNacks, 31);
    check(stopCnt == 1, "R6 stop", stopCnt, 1);
    check(errFlag == 0, "R4 no error", errFlag, 0);
    check(minSettle >= DIV, "R2 settle", minSettle, DIV);
  endtask

  task automatic t_period;
    int falls = 0, t2 = 0, t3 = 0;
    logic prev;
    clearModel(0, 0, 0);
    pulseStart(8'h44, 1);
    prev = sclOe;
    while (falls < 3) begin
      @(negedge clk);
      if (prev && !sclOe) begin
        falls++;
        if (falls == 2) t2 = cycle;
        if (falls == 3) t3 = cycle;
      end
      prev = sclOe;
    end
    check(t3 - t2 == 4 * DIV, "R11 period", t3 - t2, 4 * DIV);
    waitIdle("R11");
    checkData("R11 data", 8'h44, 1);
  endtask

  task automatic t_stall;
    logic [7:0] held;
    int n = 0;
    clearModel(0, 0, 0);
    rdReady = 1'b0;
    pulseStart(8'hF0, 2);
    while (!rdValid && n < 5000) begin @(negedge clk); n++; end
    held = rdData;
    repeat (40) @(negedge clk);
    check(rdValid == 1 && rdData == held, "R5 hold", rdData, held);
    check(sclOe == 1, "R5 scl low", sclOe, 1);
    check(masterAcks == 0, "R5 no ack yet", masterAcks, 0);
    rdReady = 1'b1;
    waitIdle("R5 stall");
    checkData("R5 stall", 8'hF0, 2);
  endtask

  task automatic t_zero;
    clearModel(0, 0, 0);
    pulseStart(8'h07, 0);
    waitIdle("R6 zero");
    checkData("R6 zero", 8'h07, 1);
    check(masterNacks == 1 && masterAcks == 0, "R6 nack only", masterAcks * 10 + masterNacks, 1);
  endtask

  task automatic t_poll;
    clearModel(3, 0, 0);
    pulseStart(8'h33, 2);
    waitIdle("R7 poll");
    checkData("R7 poll", 8'h33, 2);
    check(startCnt == 5, "R7 starts", startCnt, 5);
    check(seenA0 == 4, "R7 resends", seenA0, 4);
    check(errFlag == 0, "R7 no error", errFlag, 0);
  endtask

  task automatic t_exhaust;
    clearModel(100, 0, 0);
    pulseStart(8'h01, 2);
    waitIdle("R8 exhaust");
    check(errFlag == 1, "R8 error", errFlag, 1);
    check(seenA0 == POLL, "R8 attempts", seenA0, POLL);
    check(nGot == 0, "R8 no data", nGot, 0);
    check(stopCnt == 1, "R8 stop", stopCnt, 1);
  endtask

  task automatic t_err_clear;
    clearModel(0, 0, 0);
    pulseStart(8'h02, 1);
    check(errFlag == 0 && busy == 1, "R12 cleared", errFlag, 0);
    waitIdle("R12");
  endtask

  task automatic t_nack_off;
    clearModel(0, 1, 0);
    pulseStart(8'h05, 2);
    waitIdle("R9 offset");
    check(errFlag == 1, "R9 offset error", errFlag, 1);
    check(nGot == 0 && seenA1 == 0, "R9 offset no read", nGot + seenA1, 0);
    check(stopCnt == 1, "R9 offset stop", stopCnt, 1);
  endtask

  task automatic t_nack_rd;
    clearModel(0, 0, 1);
    pulseStart(8'h06, 2);
    waitIdle("R9 read addr");
    check(errFlag == 1, "R9 read error", errFlag, 1);
    check(nGot == 0, "R9 read no data", nGot, 0);
    check(stopCnt == 1, "R9 read stop", stopCnt, 1);
  endtask

  task automatic t_busy_ignore;
    clearModel(0, 0, 0);
    pulseStart(8'h20, 3);
    repeat (30) @(negedge clk);
    pulseStart(8'h80, 1);
    waitIdle("R10");
    checkData("R10 data", 8'h20, 3);
    check(offsetSeen == 8'h20, "R10 offset", offsetSeen, 8'h20);
    check(startCnt == 2, "R10 starts", startCnt, 2);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_period();
    t_stall();
    t_zero();
    t_poll();
    t_exhaust();
    t_err_clear();
    t_nack_off();
    t_nack_rd();
    t_busy_ignore();
    finishRun();
  end

  initial begin
    wait (cycle > 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycle, 150000);
    finishRun();
  end

endmodule